// File: doc/BRIEF.md
# Compressed Data FIFO with Service Levels

This block buffers compressed video words between an internal entropy coder and a host bus. It holds `DEPTH` words of `WIDTH` bits and works in one of two directions, chosen by `enc_mode`. In encode the coder pushes words through a valid/ready port and the host pops them with read strobes. In decode the host pushes words with write strobes and the coder pops them through a valid/ready port. Every stored word carries a one-bit end-of-field tag, and the tag drives the last-code flag.

The host can make full-width accesses or two half-width accesses. In half-width mode the low half comes first, and only the high-half access moves the FIFO. Four plain status outputs are produced. The service request is a level compared against two 4-bit service levels, one per direction, counted in steps of `LVL_STEP` entries, where a level of 0 turns the request off. The stop flag means empty in encode, and in decode it means "nearly full" with `STOP_MARGIN` entries to spare. The error flag is a one-cycle pulse for a dropped access. The last-code flag tells the host that its next read returns the final word of a field.

Back-pressure rules. The coder input completes a transfer only when `cin_valid` and `cin_ready` are high on the same edge, and the coder must hold the word until then. The coder output completes a transfer on `cout_valid && cout_ready`. Host strobes have no handshake: an access the FIFO cannot take is dropped and reported on `err`.

Top module: `cfifo_top`

## Requirements
- R1: Words leave in the order they entered, each with its data and end-of-field tag intact. The FIFO never holds more than `DEPTH` words.
- R2: Encode (`enc_mode`=1): `cin_ready` is high exactly when fewer than `DEPTH` words are held. A full-width host read returns the oldest word on `host_rdata` in the same cycle and removes it at the edge. A host read of an empty FIFO is ignored and does not raise `err`.
- R3: Decode (`enc_mode`=0): a full-width host write stores `host_wdata`. `cout_valid` is high exactly when the FIFO is not empty, `cout_data` shows the oldest word, and that word is removed on `cout_valid && cout_ready`.
- R4: Half-width mode (`host_half`=1) uses `host_hi`=0 for the low half and 1 for the high half. A low write latches `host_wdata[15:0]`. A high write stores `{host_wdata[15:0], latched low}`. A read returns the selected half of the oldest word in `host_rdata[15:0]`, with bits 31:16 zero. Only the high-half access adds or removes a word.
- R5: In encode, `srq` is high when the encode level is non-zero and the word count is at least level × `LVL_STEP`.
- R6: In decode, `srq` is high when the decode level is non-zero and the number of free entries is at least level × `LVL_STEP`.
- R7: `stop` is high when the FIFO is empty in encode. In decode it is high when the count is at least `DEPTH`−`STOP_MARGIN`.
- R8: `err` is high for exactly the one cycle after one of these dropped accesses: a coder word offered while the FIFO is full (encode), a committing host write while the FIFO is full (decode), or `cout_ready` while the FIFO is empty (decode). The dropped access leaves the contents unchanged.
- R9: `last_code` is high when, in encode, the FIFO is not empty and the oldest word carries the end-of-field tag.
- R10: Accesses from the wrong direction are ignored. In encode, host writes have no effect and `cout_valid` is 0. In decode, host reads and coder input have no effect and `cin_ready` is 0.
- R11: After reset the FIFO is empty, `err` and `last_code` are 0, and the flags follow R5 to R7 for an empty FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_mode | input | 1 | 1 = encode, 0 = decode |
| enc_lvl | input | 4 | Encode service level, in steps of LVL_STEP words |
| dec_lvl | input | 4 | Decode service level, in steps of LVL_STEP free entries |
| cin_valid | input | 1 | Coder word offered (encode) |
| cin_ready | output | 1 | FIFO accepts the coder word |
| cin_data | input | WIDTH | Coder word |
| cin_eof | input | 1 | Coder word ends a field |
| cout_valid | output | 1 | Word available to the coder (decode) |
| cout_ready | input | 1 | Coder takes the word |
| cout_data | output | WIDTH | Oldest word |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_half | input | 1 | Half-width access mode |
| host_hi | input | 1 | High-half select in half-width mode |
| host_wdata | input | WIDTH | Host write data |
| host_rdata | output | WIDTH | Host read data |
| srq | output | 1 | Service request level |
| stop | output | 1 | Empty (encode) or nearly full (decode) |
| err | output | 1 | One-cycle dropped-access pulse |
| last_code | output | 1 | Next host read returns the field's last word |

## Verification
The bench builds the block with `DEPTH`=64, `LVL_STEP`=4 and `STOP_MARGIN`=4 and keeps `WIDTH`=32. This lets a few hundred cycles fill and drain the FIFO many times. Every service level from 1 to 15 then maps to a threshold that can actually be reached (4 to 60 entries). Random traffic therefore crosses each service-request edge and the early decode stop point. It also reaches the full and empty corners where dropped accesses must pulse `err`.

// File: rtl/cfifo_pkg.sv
`timescale 1ns/1ps
package cfifo_pkg;
  // width of each direction's service level field
  localparam int LVL_W = 4;

  typedef enum logic {
    DIR_DEC = 1'b0,
    DIR_ENC = 1'b1
  } dir_e;

  // threshold in entries for a service level
  function automatic int unsigned lvl_entries(input logic [LVL_W-1:0] lvl,
                                              input int unsigned step);
    return 32'(lvl) * step;
  endfunction
endpackage

// File: rtl/cfifo_store.sv
`timescale 1ns/1ps
module cfifo_store #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             push_tag,
  input  logic             pop,
  output logic [WIDTH-1:0] head_data,
  output logic             head_tag,
  output logic [CNT_W-1:0] count
);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH:0]   mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {push_tag, push_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + PTR_W'(1);
      if (pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + PTR_W'(1);
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign {head_tag, head_data} = mem[rd_ptr];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < FULL_CNT || pop)); // R1
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0)); // R1
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT); // R1
endmodule

// File: rtl/cfifo_host.sv
`timescale 1ns/1ps
module cfifo_host #(
  parameter int WIDTH = 32,
  localparam int HALF = WIDTH / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             rd,
  input  logic             half,
  input  logic             hi,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] head_data,
  output logic             wr_req,
  output logic [WIDTH-1:0] wr_word,
  output logic             rd_req,
  output logic [WIDTH-1:0] rdata
);
  logic            commit;
  logic [HALF-1:0] lo_q;

  // only a full-width access or the high half moves the FIFO
  assign commit = !half || hi;
  assign wr_req = wr && commit;
  assign rd_req = rd && commit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 lo_q <= '0;
    else if (wr && half && !hi) lo_q <= wdata[HALF-1:0];
  end

  always_comb begin
    if (half) begin
      wr_word = {wdata[HALF-1:0], lo_q};
      rdata   = {{(WIDTH-HALF){1'b0}},
                 hi ? head_data[WIDTH-1:HALF] : head_data[HALF-1:0]};
    end else begin
      wr_word = wdata;
      rdata   = head_data;
    end
  end
endmodule

// File: rtl/cfifo_flags.sv
`timescale 1ns/1ps
module cfifo_flags
  import cfifo_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int STEP   = 32,
  parameter int MARGIN = 32,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dir_e             dir,
  input  logic [LVL_W-1:0] enc_lvl,
  input  logic [LVL_W-1:0] dec_lvl,
  input  logic [CNT_W-1:0] count,
  output logic             srq,
  output logic             stop
);
  int unsigned fill, room;
  logic        enc_srq, dec_srq, dec_stop;

  assign fill = 32'(count);
  assign room = 32'(DEPTH) - fill;

  assign enc_srq = (enc_lvl != '0) && (fill >= lvl_entries(enc_lvl, STEP));
  assign dec_srq = (dec_lvl != '0) && (room >= lvl_entries(dec_lvl, STEP));

  generate
    if (MARGIN == 0) begin : g_stop_full
      assign dec_stop = (fill == 32'(DEPTH));
    end else begin : g_stop_early
      assign dec_stop = (fill >= 32'(DEPTH - MARGIN));
    end
  endgenerate

  assign srq  = (dir == DIR_ENC) ? enc_srq : dec_srq;
  assign stop = (dir == DIR_ENC) ? (count == '0) : dec_stop;

  AST_SRQ_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (dir == DIR_ENC && enc_lvl == '0) |-> !srq); // R5
  AST_DEC_SRQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (dir == DIR_DEC && dec_lvl != '0 && count == '0) |-> srq); // R6
endmodule

// File: rtl/cfifo_top.sv
`timescale 1ns/1ps
module cfifo_top
  import cfifo_pkg::*;
#(
  parameter int DEPTH       = 512,
  parameter int WIDTH       = 32,
  parameter int LVL_STEP    = 32,
  parameter int STOP_MARGIN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_mode,
  input  logic [3:0]       enc_lvl,
  input  logic [3:0]       dec_lvl,
  input  logic             cin_valid,
  output logic             cin_ready,
  input  logic [WIDTH-1:0] cin_data,
  input  logic             cin_eof,
  output logic             cout_valid,
  input  logic             cout_ready,
  output logic [WIDTH-1:0] cout_data,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic             host_half,
  input  logic             host_hi,
  input  logic [WIDTH-1:0] host_wdata,
  output logic [WIDTH-1:0] host_rdata,
  output logic             srq,
  output logic             stop,
  output logic             err,
  output logic             last_code
);
  localparam int CNT_W = $clog2(DEPTH) + 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  dir_e             dir;
  logic [CNT_W-1:0] count;
  logic             full, empty;
  logic [WIDTH-1:0] head_data, wr_word, push_data;
  logic             head_tag, wr_req, rd_req;
  logic             push, pop, push_tag, err_d;

  assign dir   = enc_mode ? DIR_ENC : DIR_DEC;
  assign full  = (count == FULL_CNT);
  assign empty = (count == '0);

  cfifo_host #(.WIDTH(WIDTH)) u_host (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (host_wr && dir == DIR_DEC),
    .rd        (host_rd && dir == DIR_ENC),
    .half      (host_half),
    .hi        (host_hi),
    .wdata     (host_wdata),
    .head_data (head_data),
    .wr_req    (wr_req),
    .wr_word   (wr_word),
    .rd_req    (rd_req),
    .rdata     (host_rdata)
  );

  assign cin_ready  = (dir == DIR_ENC) && !full;
  assign cout_valid = (dir == DIR_DEC) && !empty;
  assign cout_data  = head_data;

  always_comb begin
    if (dir == DIR_ENC) begin
      push      = cin_valid && cin_ready;
      pop       = rd_req && !empty;
      push_data = cin_data;
      push_tag  = cin_eof;
      err_d     = cin_valid && full;
    end else begin
      push      = wr_req && !full;
      pop       = cout_valid && cout_ready;
      push_data = wr_word;
      push_tag  = 1'b0;
      err_d     = (wr_req && full) || (cout_ready && empty);
    end
  end

  cfifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (push_data),
    .push_tag  (push_tag),
    .pop       (pop),
    .head_data (head_data),
    .head_tag  (head_tag),
    .count     (count)
  );

  cfifo_flags #(.DEPTH(DEPTH), .STEP(LVL_STEP), .MARGIN(STOP_MARGIN)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .dir     (dir),
    .enc_lvl (enc_lvl),
    .dec_lvl (dec_lvl),
    .count   (count),
    .srq     (srq),
    .stop    (stop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= 1'b0;
    else        err <= err_d;
  end

  assign last_code = (dir == DIR_ENC) && !empty && head_tag;

  AST_HALF_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_mode && host_rd && host_half && !host_hi && !(cin_valid && cin_ready))
      |=> (count == $past(count))); // R4
  AST_LAST_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    last_code |-> !stop); // R9
  AST_DEC_STOP_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (!enc_mode && full) |-> stop); // R7
  AST_DROP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!enc_mode && host_wr && (!host_half || host_hi) && full && !cout_ready)
      |=> (err && count == $past(count))); // R8
  AST_WRONG_DIR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cin_ready && cout_valid)); // R10
endmodule

// File: tb/sim_cfifo_top.sv
`timescale 1ns/1ps
module sim_cfifo_top;
  localparam int D  = 64;
  localparam int W  = 32;
  localparam int ST = 4;
  localparam int MG = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic enc_mode;
  logic [3:0] enc_lvl, dec_lvl;
  logic cin_valid, cin_ready, cin_eof;
  logic [W-1:0] cin_data;
  logic cout_valid, cout_ready;
  logic [W-1:0] cout_data;
  logic host_wr, host_rd, host_half, host_hi;
  logic [W-1:0] host_wdata, host_rdata;
  logic srq, stop, err, last_code;

  always #5 clk = ~clk;

  cfifo_top #(.DEPTH(D), .WIDTH(W), .LVL_STEP(ST), .STOP_MARGIN(MG)) u0 (
    .clk(clk), .rst_n(rst_n), .enc_mode(enc_mode), .enc_lvl(enc_lvl), .dec_lvl(dec_lvl),
    .cin_valid(cin_valid), .cin_ready(cin_ready), .cin_data(cin_data), .cin_eof(cin_eof),
    .cout_valid(cout_valid), .cout_ready(cout_ready), .cout_data(cout_data),
    .host_wr(host_wr), .host_rd(host_rd), .host_half(host_half), .host_hi(host_hi),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .srq(srq), .stop(stop), .err(err), .last_code(last_code));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [32:0] q[$];
  logic [15:0] lo_m = '0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit e_srq(bit enc, int sz, int el, int dl);
    if (enc) return (el != 0) && (sz >= el * ST);
    return (dl != 0) && ((D - sz) >= dl * ST);
  endfunction

  function automatic bit e_stop(bit enc, int sz);
    if (enc) return sz == 0;
    return sz >= D - MG;
  endfunction

  task automatic idle();
    cin_valid = 0; cout_ready = 0; host_wr = 0; host_rd = 0;
    host_half = 0; host_hi = 0; cin_eof = 0;
  endtask

  // one clock with the currently driven inputs; inputs set just after an edge
  task automatic cycle();
    int sz;
    bit push, pop, e_err, commit;
    logic [32:0] item;
    logic [31:0] head;
    #2;
    sz = q.size();
    head = (sz > 0) ? q[0][31:0] : '0;
    commit = !host_half || host_hi;
    push = 0; pop = 0; e_err = 0; item = '0;
    if (enc_mode) begin
      chk("R2", "cin_ready", cin_ready, sz < D);
      chk("R10", "cout_valid in encode", cout_valid, 0);
      if (host_rd && sz > 0) begin
        if (host_half) chk("R4", "half read data", host_rdata,
                           {16'h0, host_hi ? head[31:16] : head[15:0]});
        else chk("R1 R2", "read data", host_rdata, head);
      end
      push  = cin_valid && sz < D;
      e_err = cin_valid && sz == D;
      pop   = host_rd && commit && sz > 0;
      item  = {cin_eof, cin_data};
    end else begin
      chk("R10", "cin_ready in decode", cin_ready, 0);
      chk("R3", "cout_valid", cout_valid, sz > 0);
      if (sz > 0) chk("R1 R3", "cout_data", cout_data, head);
      push  = host_wr && commit && sz < D;
      e_err = (host_wr && commit && sz == D) || (cout_ready && sz == 0);
      pop   = cout_ready && sz > 0;
      item  = {1'b0, host_half ? {host_wdata[15:0], lo_m} : host_wdata};
      if (host_wr && host_half && !host_hi) lo_m = host_wdata[15:0];
    end
    if (pop)  void'(q.pop_front());
    if (push) q.push_back(item);
    @(posedge clk);
    #1;
    sz = q.size();
    chk("R8", "err", err, e_err);
    chk(enc_mode ? "R5" : "R6", "srq", srq, e_srq(enc_mode, sz, enc_lvl, dec_lvl));
    chk("R7", "stop", stop, e_stop(enc_mode, sz));
    chk("R9", "last_code", last_code, enc_mode && sz > 0 && q[0][32]);
  endtask

  task automatic rand_traffic(int n, int p_push, int p_pop);
    for (int i = 0; i < n; i++) begin
      if (i % 40 == 0) begin
        enc_lvl = 4'($urandom_range(0, 15));
        dec_lvl = 4'($urandom_range(0, 15));
        host_half = 1'($urandom_range(0, 1));
      end
      host_hi    = 1'($urandom_range(0, 1));
      cin_valid  = ($urandom_range(0, 99) < p_push);
      host_wr    = ($urandom_range(0, 99) < p_push);
      host_rd    = ($urandom_range(0, 99) < p_pop);
      cout_ready = ($urandom_range(0, 99) < p_pop);
      cin_data   = $urandom;
      host_wdata = $urandom;
      cin_eof    = ($urandom_range(0, 3) == 0);
      cycle();
    end
    idle();
  endtask

  initial begin
    void'($urandom(32'd1357));
    rst_n = 0; enc_mode = 1; enc_lvl = 4'd8; dec_lvl = 4'd8;
    cin_data = '0; host_wdata = '0;
    idle();
    repeat (3) @(posedge clk);
    #1;
    // R11: reset state, encode, empty
    chk("R11", "stop after reset", stop, 1);
    chk("R11", "srq after reset", srq, 0);
    chk("R11", "err after reset", err, 0);
    chk("R11", "last_code after reset", last_code, 0);
    chk("R11", "cin_ready after reset", cin_ready, 1);
    rst_n = 1;
    @(posedge clk); #1;

    // encode: random fill/drain phases
    for (int k = 0; k < 6; k++) begin
      rand_traffic(150, 80, 30);
      rand_traffic(150, 30, 80);
    end

    // encode directed: fill past full at level 15 (threshold 60)
    enc_lvl = 4'd15;
    for (int i = 0; i < D + 3; i++) begin
      cin_valid = 1; cin_data = $urandom; cin_eof = (i % 5 == 4);
      cycle();
    end
    idle();
    // half reads: low twice then high (R4), then drain plus reads when empty (R2)
    host_half = 1;
    host_rd = 1; host_hi = 0; cycle(); cycle();
    host_hi = 1; cycle();
    host_half = 0;
    for (int i = 0; i < D + 4; i++) begin
      host_rd = 1; cycle();
    end
    idle();

    // decode
    enc_mode = 0;
    cycle();
    for (int k = 0; k < 6; k++) begin
      rand_traffic(150, 80, 30);
      rand_traffic(150, 30, 80);
    end
    // decode directed: fill past full, half and full width writes
    dec_lvl = 4'd2;
    for (int i = 0; i < D + 3; i++) begin
      host_wr = 1; host_wdata = $urandom;
      host_half = (i % 3 == 0); host_hi = 0;
      if (host_half) begin cycle(); host_wdata = $urandom; host_hi = 1; end
      cycle();
    end
    idle();
    for (int i = 0; i < D + 3; i++) begin
      cout_ready = 1; host_rd = 1; cin_valid = 1; cycle();
    end
    idle();
    cycle();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule